// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA

This block moves transmit data from memory to a byte stream without processor help. Software builds a ring of descriptors in memory. Each descriptor is four 32-bit words: a control word at offset 0, a pointer to the next descriptor at offset 4, a pointer to the data buffer at offset 8, and a status word at offset 12. Software writes the address of the first descriptor into a register and issues a start command. The engine then walks the ring. For each descriptor it reads the buffer words, sends the bytes on a valid/ready stream, and writes a completion flag back into the status word.

A descriptor whose control word carries the hold bit is a barrier. The engine stays on it and re-reads its control word after a programmable polling interval. It moves on once software has cleared the bit. A release command makes it re-read at once instead of waiting. Completion events can raise an interrupt line through a mask register and a write-one-to-clear status register.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the stream is idle, there are no memory requests, the interrupt line is low, interrupt status reads 0 and the polling interval reads 7.
- R2: Writing value 1 to the command register (address 0) starts the engine. Its first memory read is the control word at the address held in the start register (address 1).
- R3: For a descriptor that is not held, the engine sends exactly the byte count given in control bits 21:0. It reads the buffer word by word from the data pointer and sends byte lane 0 of each word first.
- R4: `out_first` marks the first byte of a descriptor whose control bit 29 is set. `out_last` marks the final byte of a descriptor whose control bit 30 is set. Neither flag appears on any other byte.
- R5: While control bit 31 (hold) is set, the engine sends nothing from that descriptor. It re-reads the control word once per interval, where the interval is the polling register value (address 2) times a fixed prescaler of 4 cycles.
- R6: Writing value 2 to the command register while the engine is held makes it re-read the control word within a few cycles, without waiting out the interval.
- R7: After the last byte of a descriptor, the engine writes its status word at offset 12. It sets bit 31 and puts the byte count in bits 21:0. It then follows the next pointer, so the last descriptor leads back to the first.
- R8: The ring wraps: after the last descriptor, the next control read is at the first descriptor's address.
- R9: On completion, interrupt status bit 0 is set if control bit 28 was set. Bit 1 is set if both control bits 27 and 30 were set. Writing a 1 to a status bit (address 4) clears it.
- R10: Writing value 0 to the command register stops the engine. No further memory requests are made and no bytes are sent.
- R11: The interrupt mask (address 3) resets to all ones. The interrupt line is high only while some status bit is set and its mask bit is clear.
- R12: While `out_valid` is high and `out_ready` is low, the byte and its flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 command, 1 start, 2 poll, 3 mask, 4 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_first | output | 1 | First byte of a packet |
| out_last | output | 1 | Last byte of a packet |
| out_ready | input | 1 | Stream consumer ready |
| irq | output | 1 | Interrupt request |

## Verification
A wrong descriptor pointer or byte counter shows up at the stream within one memory round trip. It appears as a byte from the wrong buffer, a missing or extra byte, or a misplaced first/last flag. The bench compares every beat against a queue it builds from the descriptors. A stuck hold or poll state shows in the spacing of control-word reads on the memory port, which is measured against the programmed interval to within a few cycles. Mistakes in completion bookkeeping appear in the status words in memory and in the interrupt registers, which are read right after the descriptors finish.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
    // control word bit positions (software layout, behaviour depends on them)
    localparam int CTL_HOLD = 31;
    localparam int CTL_EOP  = 30;
    localparam int CTL_SOP  = 29;
    localparam int CTL_ICPT = 28;
    localparam int CTL_IEOP = 27;

    // register addresses
    localparam logic [2:0] RA_CMD    = 3'd0;
    localparam logic [2:0] RA_START  = 3'd1;
    localparam logic [2:0] RA_POLL   = 3'd2;
    localparam logic [2:0] RA_MASK   = 3'd3;
    localparam logic [2:0] RA_STATUS = 3'd4;

    // command codes
    localparam logic [1:0] CMD_OFF     = 2'd0;
    localparam logic [1:0] CMD_INIT    = 2'd1;
    localparam logic [1:0] CMD_RELEASE = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_NEXT,
        ST_DPTR,
        ST_POLL,
        ST_FETCH,
        ST_SEND,
        ST_STAT
    } eng_state_e;
endpackage

// File: rtl/txdesc_regs.sv
module txdesc_regs
    import txdesc_pkg::*;
#(
    parameter int AW       = 32,
    parameter int POLL_W   = 8,
    parameter int POLL_RST = 7,
    parameter int NUM_IRQ  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_IRQ-1:0] irq_set,
    output logic               cmd_off,
    output logic               cmd_init,
    output logic               cmd_release,
    output logic [AW-1:0]      start_addr,
    output logic [POLL_W-1:0]  poll_ival,
    output logic               irq
);
    typedef struct packed {
        logic [AW-1:0]      start;
        logic [POLL_W-1:0]  poll;
        logic [NUM_IRQ-1:0] mask;
        logic [NUM_IRQ-1:0] status;
    } regs_t;

    regs_t q, d;
    logic  wr_cmd;

    assign wr_cmd      = reg_we && (reg_addr == RA_CMD);
    assign cmd_off     = wr_cmd && (reg_wdata[1:0] == CMD_OFF);
    assign cmd_init    = wr_cmd && (reg_wdata[1:0] == CMD_INIT);
    assign cmd_release = wr_cmd && (reg_wdata[1:0] == CMD_RELEASE);

    always_comb begin
        d = q;
        if (reg_we && reg_addr == RA_START)  d.start = reg_wdata[AW-1:0];
        if (reg_we && reg_addr == RA_POLL)   d.poll  = reg_wdata[POLL_W-1:0];
        if (reg_we && reg_addr == RA_MASK)   d.mask  = reg_wdata[NUM_IRQ-1:0];
        if (reg_we && reg_addr == RA_STATUS) d.status = q.status & ~reg_wdata[NUM_IRQ-1:0];
        d.status = d.status | irq_set;   // a new event wins over a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.start  <= '0;
            q.poll   <= POLL_W'(POLL_RST);
            q.mask   <= '1;
            q.status <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_START:  reg_rdata[AW-1:0]      = q.start;
            RA_POLL:   reg_rdata[POLL_W-1:0]  = q.poll;
            RA_MASK:   reg_rdata[NUM_IRQ-1:0] = q.mask;
            RA_STATUS: reg_rdata[NUM_IRQ-1:0] = q.status;
            default:   reg_rdata = '0;
        endcase
    end

    assign start_addr = q.start;
    assign poll_ival  = q.poll;
    assign irq        = |(q.status & ~q.mask);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_STATUS && irq_set == '0)
        |=> ((q.status & $past(reg_wdata[NUM_IRQ-1:0])) == '0)); // R9

    AST_MASK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_MASK) |=> (q.mask == $past(reg_wdata[NUM_IRQ-1:0]))); // R11
endmodule

// File: rtl/txdesc_poll_timer.sv
module txdesc_poll_timer #(
    parameter int POLL_W   = 8,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [POLL_W-1:0] ival,
    output logic              done
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [POLL_W-1:0] cnt;
        logic              run;
        logic              done;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (start) begin
            d.pre = PRE_TOP;
            d.cnt = ival;
            d.run = (ival != '0);
            d.done = (ival == '0);
        end else if (q.run) begin
            if (q.pre == '0) begin
                d.pre = PRE_TOP;
                d.cnt = q.cnt - 1'b1;
                if (q.cnt == POLL_W'(1)) begin
                    d.run  = 1'b0;
                    d.done = 1'b1;
                end
            end else begin
                d.pre = q.pre - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine
    import txdesc_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_off,
    input  logic          cmd_init,
    input  logic          cmd_release,
    input  logic [AW-1:0] start_addr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_first,
    output logic          out_last,
    input  logic          out_ready,
    output logic          poll_start,
    input  logic          poll_done,
    output logic          ev_cpt,
    output logic          ev_eop
);
    localparam logic [AW-1:0] OFS_NEXT = AW'(4);
    localparam logic [AW-1:0] OFS_DPTR = AW'(8);
    localparam logic [AW-1:0] OFS_STAT = AW'(12);
    localparam logic [AW-1:0] WORD_B   = AW'(4);

    typedef struct packed {
        eng_state_e    st;
        logic [AW-1:0] desc;
        logic [31:0]   ctrl;
        logic [AW-1:0] nxt;
        logic [AW-1:0] waddr;
        logic [31:0]   word;
        logic [1:0]    lane;
        logic [CW-1:0] left;
        logic          first;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d          = q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = q.desc;
        mem_wdata  = '0;
        out_valid  = 1'b0;
        poll_start = 1'b0;
        ev_cpt     = 1'b0;
        ev_eop     = 1'b0;

        case (q.st)
            ST_CTRL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    d.ctrl = mem_rdata;
                    if (mem_rdata[CTL_HOLD]) begin
                        d.st       = ST_POLL;
                        poll_start = 1'b1;
                    end else begin
                        d.st = ST_NEXT;
                    end
                end
            end
            ST_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = q.desc + OFS_NEXT;
                if (mem_ack) begin
                    d.nxt = mem_rdata[AW-1:0];
                    d.st  = ST_DPTR;
                end
            end
            ST_DPTR: begin
                mem_req  = 1'b1;
                mem_addr = q.desc + OFS_DPTR;
                if (mem_ack) begin
                    d.waddr = mem_rdata[AW-1:0];
                    d.left  = q.ctrl[CW-1:0];
                    d.lane  = 2'd0;
                    d.first = q.ctrl[CTL_SOP];
                    d.st    = (q.ctrl[CW-1:0] == '0) ? ST_STAT : ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.waddr;
                if (mem_ack) begin
                    d.word  = mem_rdata;
                    d.waddr = q.waddr + WORD_B;
                    d.st    = ST_SEND;
                end
            end
            ST_SEND: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    d.first = 1'b0;
                    d.left  = q.left - 1'b1;
                    d.lane  = q.lane + 2'd1;
                    if (q.left == CW'(1))    d.st = ST_STAT;
                    else if (q.lane == 2'd3) d.st = ST_FETCH;
                end
            end
            ST_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.desc + OFS_STAT;
                mem_wdata = {1'b1, {(31 - CW){1'b0}}, q.ctrl[CW-1:0]};
                if (mem_ack) begin
                    ev_cpt = q.ctrl[CTL_ICPT];
                    ev_eop = q.ctrl[CTL_IEOP] & q.ctrl[CTL_EOP];
                    d.desc = q.nxt;
                    d.st   = ST_CTRL;
                end
            end
            ST_POLL: begin
                if (poll_done || cmd_release) d.st = ST_CTRL;
            end
            default: begin
                d.st = q.st;
            end
        endcase

        if (cmd_init) begin
            d.desc = start_addr;
            d.st   = ST_CTRL;
        end
        if (cmd_off) d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign out_data  = q.word[{q.lane, 3'b000} +: 8];
    assign out_first = out_valid && q.first;
    assign out_last  = out_valid && (q.left == CW'(1)) && q.ctrl[CTL_EOP];

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !cmd_off && !cmd_init)
        |=> (out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last))); // R12

    AST_NO_SEND_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !q.ctrl[CTL_HOLD]); // R5

    AST_STAT_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (q.left == '0)); // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cmd_off && !cmd_init)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
    import txdesc_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 22,
    parameter int POLL_W   = 8,
    parameter int POLL_RST = 7,
    parameter int PRESCALE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_first,
    output logic          out_last,
    input  logic          out_ready,
    output logic          irq
);
    localparam int NUM_IRQ = 2;

    logic              cmd_off, cmd_init, cmd_release;
    logic [AW-1:0]     start_addr;
    logic [POLL_W-1:0] poll_ival;
    logic              poll_start, poll_done;
    logic              ev_cpt, ev_eop;

    txdesc_regs #(
        .AW(AW), .POLL_W(POLL_W), .POLL_RST(POLL_RST), .NUM_IRQ(NUM_IRQ)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_set({ev_eop, ev_cpt}),
        .cmd_off(cmd_off), .cmd_init(cmd_init), .cmd_release(cmd_release),
        .start_addr(start_addr), .poll_ival(poll_ival), .irq(irq)
    );

    txdesc_poll_timer #(
        .POLL_W(POLL_W), .PRESCALE(PRESCALE)
    ) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start(poll_start), .ival(poll_ival), .done(poll_done)
    );

    txdesc_engine #(
        .AW(AW), .CW(CW)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_off(cmd_off), .cmd_init(cmd_init), .cmd_release(cmd_release),
        .start_addr(start_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_ready(out_ready),
        .poll_start(poll_start), .poll_done(poll_done),
        .ev_cpt(ev_cpt), .ev_eop(ev_eop)
    );
endmodule

// File: tb/test_txdesc_dma.sv
`timescale 1ns/1ps
module test_txdesc_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        out_valid, out_first, out_last;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic        irq;

    always #4 clk = ~clk;

    txdesc_dma i_txdesc_dma (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_ready(out_ready), .irq(irq)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [0:255];
    logic        ack_q = 1'b0;
    logic [31:0] rd_q  = '0;
    logic        first_seen = 1'b0;
    logic [31:0] first_addr = '0;
    int          d2_times[$];
    int          d0_reads = 0;
    int          req_cnt  = 0;

    assign mem_ack   = ack_q;
    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) req_cnt <= req_cnt + 1;
        ack_q <= 1'b0;
        if (rst_n && mem_req && !ack_q) begin
            ack_q <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
            end else begin
                rd_q <= mem[mem_addr[9:2]];
                if (!first_seen) begin
                    first_seen <= 1'b1;
                    first_addr <= mem_addr;
                end
                if (mem_addr == 32'h120) d2_times.push_back(cyc);
                if (mem_addr == 32'h100) d0_reads <= d0_reads + 1;
            end
        end
    end

    // ---------------- stream reference model ----------------
    logic [9:0] expq[$];   // {first, last, byte}

    always @(posedge clk) begin
        #2 out_ready = (cyc % 3) != 2;
    end

    logic       pv = 1'b0, pr = 1'b0, pf = 1'b0, pl = 1'b0;
    logic [7:0] pd = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pv && !pr)
                check(out_valid && {out_first, out_last, out_data} == {pf, pl, pd},
                      "R12 beat stable under backpressure",
                      {out_valid, out_first, out_last, out_data}, {1'b1, pf, pl, pd});
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R5 R3 unexpected beat", {out_first, out_last, out_data}, 0);
                end else begin
                    logic [9:0] e;
                    e = expq.pop_front();
                    check({out_first, out_last, out_data} == e, "R3 R4 beat content",
                          {out_first, out_last, out_data}, e);
                end
            end
            pv = out_valid; pr = out_ready; pf = out_first; pl = out_last; pd = out_data;
        end
    end

    // ---------------- register access ----------------
    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push_bytes(input logic [7:0] b[], input bit sop, input bit eop);
        foreach (b[i])
            expq.push_back({(sop && i == 0), (eop && i == b.size() - 1), b[i]});
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        logic [31:0] v;
        int rel_cyc, rc0;

        foreach (mem[i]) mem[i] = '0;
        // d0 @0x100: SOP|ICPT, 5 bytes
        mem[64] = 32'h3000_0005; mem[65] = 32'h110; mem[66] = 32'h200;
        // d1 @0x110: EOP|IEOP, 3 bytes
        mem[68] = 32'h4800_0003; mem[69] = 32'h120; mem[70] = 32'h240;
        // d2 @0x120: HOLD|SOP|EOP, 6 bytes, points back to d0
        mem[72] = 32'hE000_0006; mem[73] = 32'h100; mem[74] = 32'h280;
        mem[128] = 32'h4433_2211; mem[129] = 32'h0000_0055;
        mem[144] = 32'h00CC_BBAA;
        mem[160] = 32'h0403_0201; mem[161] = 32'h0000_0605;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !mem_req && !irq, "R1 idle after reset",
              {out_valid, mem_req, irq}, 0);
        reg_read(3'd2, v); check(v == 32'd7, "R1 poll reset value", v, 7);
        reg_read(3'd4, v); check(v == 0, "R1 status reset value", v, 0);
        reg_read(3'd3, v); check(v == 32'h3, "R11 mask resets to ones", v, 3);

        push_bytes('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, 1'b1, 1'b0);
        push_bytes('{8'hAA, 8'hBB, 8'hCC}, 1'b0, 1'b1);

        reg_write(3'd2, 32'd3);       // interval 3 x 4 = 12 cycles
        reg_write(3'd1, 32'h100);
        reg_write(3'd0, 32'd1);       // start

        for (int i = 0; i < 3000 && d2_times.size() < 3; i++) @(negedge clk);
        check(first_addr == 32'h100, "R2 first read at start address", first_addr, 32'h100);
        check(d2_times.size() >= 3, "R5 held descriptor re-polled", d2_times.size(), 3);
        if (d2_times.size() >= 3) begin
            int g;
            g = d2_times[2] - d2_times[1];
            check(g >= 12 && g <= 18, "R5 poll spacing", g, 15);
        end
        check(expq.size() == 0, "R3 all bytes of d0 and d1 sent", expq.size(), 0);
        check(mem[67] == 32'h8000_0005, "R7 d0 status word", mem[67], 32'h8000_0005);
        check(mem[71] == 32'h8000_0003, "R7 d1 status word", mem[71], 32'h8000_0003);
        check(mem[75] == 32'h0, "R5 held descriptor not completed", mem[75], 0);

        reg_read(3'd4, v); check(v == 32'h3, "R9 status bits set", v, 3);
        check(!irq, "R11 masked irq stays low", irq, 0);
        reg_write(3'd3, 32'h0);
        @(negedge clk); check(irq, "R11 unmasked irq high", irq, 1);
        reg_write(3'd4, 32'h1);
        reg_read(3'd4, v); check(v == 32'h2, "R9 write-one clears bit 0 only", v, 2);
        check(irq, "R11 irq with remaining bit", irq, 1);
        reg_write(3'd4, 32'h2);
        reg_read(3'd4, v); check(v == 32'h0, "R9 write-one clears bit 1", v, 0);
        check(!irq, "R11 irq low after clear", irq, 0);

        // release d2, hold d0 so the wrap stalls there
        mem[72] = 32'h6000_0006;
        mem[64] = 32'hB000_0005;
        push_bytes('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06}, 1'b1, 1'b1);
        begin
            int n0;
            n0 = d2_times.size();
            @(negedge clk);
            rel_cyc = cyc;
            reg_write(3'd0, 32'd2);
            for (int i = 0; i < 20 && d2_times.size() == n0; i++) @(negedge clk);
            check(d2_times.size() > n0 && d2_times[n0] - rel_cyc <= 5,
                  "R6 release re-reads at once",
                  (d2_times.size() > n0) ? d2_times[n0] - rel_cyc : -1, 3);
        end
        for (int i = 0; i < 3000 && d0_reads < 3; i++) @(negedge clk);
        check(d0_reads >= 3, "R8 ring wraps to first descriptor", d0_reads, 3);
        check(expq.size() == 0, "R3 d2 bytes sent", expq.size(), 0);
        check(mem[75] == 32'h8000_0006, "R7 d2 status word", mem[75], 32'h8000_0006);
        reg_read(3'd4, v); check(v == 32'h0, "R9 no event without enables", v, 0);

        reg_write(3'd0, 32'd0);       // stop
        repeat (2) @(negedge clk);
        rc0 = req_cnt;
        repeat (60) @(negedge clk);
        check(req_cnt == rc0, "R10 no requests after stop", req_cnt - rc0, 0);
        check(!out_valid, "R10 stream idle after stop", out_valid, 0);

        summary();
    end
endmodule